// File: doc/BRIEF.md
# Eight-Line Prioritised Interrupt Controller

This block collects interrupt requests from eight lines and presents them to a processor one at a time. A request that cannot be served at once is remembered in a pending latch. A mask register can block any line, and a single service-level register means only a line numbered below the level now being served can break in. When a line is chosen, the block raises a level interrupt output together with a vector number. The output stays up until the processor pulses an acknowledge. The block then holds off further deliveries until the processor's global interrupt enable rises again.

Software reaches the block through a byte-wide strobe interface with two ports. The command port takes the end-of-service code, and reads of it return a fixed status byte. The mask port can be read and written. Ending service frees the current level and moves the level up to the next line that is still in service. A status output tells the processor when some allowed line is waiting while interrupts are disabled.

Top module: `eirq_ctrl`

## Requirements
- R1: Delivering line n drives `int_o` high with `vec_o` = 8 + n. Both hold steady until a cycle with `inta_i` high, after which `int_o` is low.
- R2: After reset, `int_o` and `wait_o` are low, the mask is 0x00, the service level is idle (8), and no line is pending or in service.
- R3: Line n is allowed only when mask bit n is 0 and the service level is strictly greater than n.
- R4: A request on a line that is not allowed, or that arrives while delivery is disabled, is latched as pending and is never lost.
- R5: Delivering line n sets the level to n and marks n in service. No further delivery happens until `gie_i` has gone low and then high again.
- R6: Writing 0x20 to the command port (`reg_sel_i`=0) ends service. At idle level 8 this has no effect. Otherwise it clears the in-service mark at the current level and moves the level up to the next level still in service, or to 8.
- R7: Writing any other value to the command port changes nothing.
- R8: A read with `reg_sel_i`=0 returns 0x60.
- R9: A read with `reg_sel_i`=1 returns the mask, with bit n masking line n. Writing it replaces the mask, and any pending line it makes allowed is delivered.
- R10: When delivery is enabled, the lowest-numbered allowed pending (or newly requested) line is delivered, one line per evaluation. The others stay pending.
- R11: `wait_o` is high exactly when delivery is disabled and some pending line is allowed. It is low whenever delivery is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| req_i | input | 8 | Request strobes, one per line; a high bit in a cycle is one request |
| reg_en_i | input | 1 | Register access strobe |
| reg_we_i | input | 1 | Write when high, read when low |
| reg_sel_i | input | 1 | 0 selects the command port, 1 selects the mask port |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data for the selected port |
| gie_i | input | 1 | Processor global interrupt enable |
| int_o | output | 1 | Interrupt request to the processor |
| vec_o | output | 8 | Vector number of the delivered line |
| inta_i | input | 1 | Acknowledge pulse, clears `int_o` |
| wait_o | output | 1 | An allowed line waits while delivery is disabled |

## Verification
A new request that can be served at once, with delivery enabled, shows on `int_o` after the same clock edge that samples it. A delivery unlocked by a register write shows one edge after the write, because no delivery is made in a write cycle. After a re-enable that ends a hold-off, the delivery comes two edges after `gie_i` rises. `wait_o` and the read data follow the registered state combinationally. The bench drives stimulus on falling edges and waits three cycles before it checks `int_o`, which covers the longest of these paths. A monitor pops the expected vector from a queue on each rising `int_o`, so an early, late or extra delivery appears either as a queue mismatch or as a wrong level in the fixed-delay checks.

// File: rtl/eirq_pkg.sv
package eirq_pkg;

   typedef enum logic {
      PORT_CMD  = 1'b0,
      PORT_MASK = 1'b1
   } eirq_port_e;

   localparam int unsigned DEF_LINES  = 8;
   localparam int unsigned DEF_DATA_W = 8;

endpackage

// File: rtl/eirq_prio_pick.sv
// Lowest-index-first fixed-priority picker.
module eirq_prio_pick #(
   parameter int unsigned N     = 8,
   localparam int unsigned IDX_W = $clog2(N)
) (
   input  logic [N-1:0]     cand_i,
   output logic [N-1:0]     grant_o,
   output logic             any_o,
   output logic [IDX_W-1:0] idx_o
);

   logic [N:0] blocked;

   assign blocked[0] = 1'b0;

   for (genvar g = 0; g < N; g++) begin : g_chain
      assign grant_o[g]   = cand_i[g] & ~blocked[g];
      assign blocked[g+1] = blocked[g] | cand_i[g];
   end

   assign any_o = blocked[N];

   always_comb begin
      idx_o = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (cand_i[i]) idx_o = IDX_W'(i);
      end
   end

endmodule

// File: rtl/eirq_line_state.sv
// Pending latches and mask register.
module eirq_line_state #(
   parameter int unsigned N = 8
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic [N-1:0] req_i,
   input  logic [N-1:0] take_i,
   input  logic         mask_we_i,
   input  logic [N-1:0] mask_wdata_i,
   output logic [N-1:0] pend_o,
   output logic [N-1:0] mask_o
);

   logic [N-1:0] pend_q;
   logic [N-1:0] mask_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         pend_q <= '0;
         mask_q <= '0;
      end else begin
         pend_q <= (pend_q | req_i) & ~take_i;
         if (mask_we_i) mask_q <= mask_wdata_i;
      end
   end

   assign pend_o = pend_q;
   assign mask_o = mask_q;

   for (genvar g = 0; g < N; g++) begin : g_chk
      a_r4_pend_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (pend_q[g] && !take_i[g]) |=> pend_q[g]);
      a_r4_req_latched: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (req_i[g] && !take_i[g]) |=> pend_q[g]);
   end

endmodule

// File: rtl/eirq_level_track.sv
// Current service level, in-service marks, end-of-service walk.
module eirq_level_track #(
   parameter int unsigned N     = 8,
   localparam int unsigned IDX_W = $clog2(N),
   localparam int unsigned LVL_W = $clog2(N + 1)
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             eoi_i,
   input  logic             take_vld_i,
   input  logic [IDX_W-1:0] take_idx_i,
   output logic [LVL_W-1:0] level_o,
   output logic [N-1:0]     below_o
);

   localparam logic [LVL_W-1:0] IDLE = LVL_W'(N);

   logic [LVL_W-1:0] level_q, walk_lvl;
   logic [N-1:0]     busy_q, busy_clr, busy_set;

   always_comb begin
      busy_clr = busy_q;
      if (level_q < IDLE) busy_clr[level_q[IDX_W-1:0]] = 1'b0;
      walk_lvl = IDLE;
      for (int i = N - 1; i >= 0; i--) begin
         if (busy_clr[i] && (LVL_W'(i) > level_q)) walk_lvl = LVL_W'(i);
      end
   end

   always_comb begin
      busy_set = busy_q;
      busy_set[take_idx_i] = 1'b1;
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         level_q <= IDLE;
         busy_q  <= '0;
      end else if (take_vld_i) begin
         level_q <= LVL_W'(take_idx_i);
         busy_q  <= busy_set;
      end else if (eoi_i && (level_q < IDLE)) begin
         level_q <= walk_lvl;
         busy_q  <= busy_clr;
      end
   end

   for (genvar g = 0; g < N; g++) begin : g_below
      assign below_o[g] = (level_q > LVL_W'(g));
   end

   assign level_o = level_q;

   a_r6_idle_noop: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (eoi_i && !take_vld_i && level_q == IDLE) |=> (level_q == IDLE && $stable(busy_q)));
   a_r6_walk_up: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (eoi_i && !take_vld_i && level_q < IDLE) |=> (level_q > $past(level_q)));
   a_r6_no_overlap: assert property (@(posedge clk_i) disable iff (!rst_ni)
      eoi_i |-> !take_vld_i);

endmodule

// File: rtl/eirq_ctrl.sv
module eirq_ctrl #(
   parameter int unsigned N_LINES     = eirq_pkg::DEF_LINES,
   parameter int unsigned DATA_W      = eirq_pkg::DEF_DATA_W,
   parameter int unsigned VEC_W       = 8,
   parameter int unsigned VEC_BASE    = 8,
   parameter logic [7:0]  EOI_CODE    = 8'h20,
   parameter logic [7:0]  STATUS_CODE = 8'h60
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic [N_LINES-1:0] req_i,
   input  logic               reg_en_i,
   input  logic               reg_we_i,
   input  logic               reg_sel_i,
   input  logic [DATA_W-1:0]  reg_wdata_i,
   output logic [DATA_W-1:0]  reg_rdata_o,
   input  logic               gie_i,
   output logic               int_o,
   output logic [VEC_W-1:0]   vec_o,
   input  logic               inta_i,
   output logic               wait_o
);
   import eirq_pkg::*;

   localparam int unsigned IDX_W = $clog2(N_LINES);
   localparam int unsigned LVL_W = $clog2(N_LINES + 1);

   if (N_LINES < 2 || N_LINES > DATA_W) begin : g_bad_lines
      $error("eirq_ctrl: N_LINES must lie in 2..DATA_W");
   end
   if (DATA_W < 8) begin : g_bad_data
      $error("eirq_ctrl: DATA_W must be at least 8");
   end
   if (VEC_BASE + N_LINES > (1 << VEC_W)) begin : g_bad_vec
      $error("eirq_ctrl: vectors do not fit VEC_W");
   end

   eirq_port_e port;
   logic wr, eoi, mask_we;
   logic gie_d, gie_rise, hold_q, en_eff;
   logic int_q;
   logic [VEC_W-1:0]   vec_q;
   logic [N_LINES-1:0] pend, mask, below, allow, cand, grant;
   logic               take_vld;
   logic [IDX_W-1:0]   take_idx;
   logic [LVL_W-1:0]   level;

   assign port    = eirq_port_e'(reg_sel_i);
   assign wr      = reg_en_i & reg_we_i;
   assign eoi     = wr && (port == PORT_CMD) && (reg_wdata_i == DATA_W'(EOI_CODE));
   assign mask_we = wr && (port == PORT_MASK);

   assign gie_rise = gie_i & ~gie_d;
   assign en_eff   = gie_i & ~hold_q & ~int_q;

   assign allow = ~mask & below;
   assign cand  = (pend | req_i) & allow & {N_LINES{en_eff & ~wr}};

   eirq_prio_pick #(.N(N_LINES)) u_pick (
      .cand_i  (cand),
      .grant_o (grant),
      .any_o   (take_vld),
      .idx_o   (take_idx)
   );

   eirq_line_state #(.N(N_LINES)) u_lines (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .req_i        (req_i),
      .take_i       (grant),
      .mask_we_i    (mask_we),
      .mask_wdata_i (reg_wdata_i[N_LINES-1:0]),
      .pend_o       (pend),
      .mask_o       (mask)
   );

   eirq_level_track #(.N(N_LINES)) u_level (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .eoi_i      (eoi),
      .take_vld_i (take_vld),
      .take_idx_i (take_idx),
      .level_o    (level),
      .below_o    (below)
   );

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         gie_d  <= 1'b0;
         hold_q <= 1'b0;
         int_q  <= 1'b0;
         vec_q  <= '0;
      end else begin
         gie_d <= gie_i;
         if (take_vld)      hold_q <= 1'b1;
         else if (gie_rise) hold_q <= 1'b0;
         if (take_vld) begin
            int_q <= 1'b1;
            vec_q <= VEC_W'(VEC_BASE) + VEC_W'(take_idx);
         end else if (inta_i) begin
            int_q <= 1'b0;
         end
      end
   end

   always_comb begin
      if (port == PORT_MASK) reg_rdata_o = DATA_W'(mask);
      else                   reg_rdata_o = DATA_W'(STATUS_CODE);
   end

   assign int_o  = int_q;
   assign vec_o  = vec_q;
   assign wait_o = ~en_eff & (|(pend & allow));

   a_r1_int_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (int_o && !inta_i) |=> int_o);
   a_r1_vec_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (int_o && !inta_i) |=> $stable(vec_o));
   a_r3_grant_allowed: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (grant & ~allow) == '0);
   a_r10_one_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(grant));
   a_r5_level_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(int_o) |-> (level < $past(level)));
   a_r5_level_is_line: assert property (@(posedge clk_i) disable iff (!rst_ni)
      take_vld |=> (level == $past(LVL_W'(take_idx))));

endmodule

// File: tb/eirq_ctrl_tb_top.sv
module eirq_ctrl_tb_top;

   localparam int CLK_P = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] req = '0;
   logic       reg_en = 1'b0, reg_we = 1'b0, reg_sel = 1'b0;
   logic [7:0] reg_wdata = '0;
   logic [7:0] reg_rdata;
   logic       gie = 1'b1;
   logic       int_w;
   logic [7:0] vec;
   logic       inta = 1'b0;
   logic       wait_w;

   int n_chk = 0;
   int n_err = 0;
   bit done  = 1'b0;
   bit int_seen = 1'b0;
   int exp_q[$];

   always #(CLK_P/2) clk = ~clk;

   eirq_ctrl dut_i (
      .clk_i       (clk),
      .rst_ni      (rst_n),
      .req_i       (req),
      .reg_en_i    (reg_en),
      .reg_we_i    (reg_we),
      .reg_sel_i   (reg_sel),
      .reg_wdata_i (reg_wdata),
      .reg_rdata_o (reg_rdata),
      .gie_i       (gie),
      .int_o       (int_w),
      .vec_o       (vec),
      .inta_i      (inta),
      .wait_o      (wait_w)
   );

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   // Monitor: each rising int_o pops one expected vector.
   always @(negedge clk) begin
      if (rst_n) begin
         if (int_w && !int_seen) begin
            int_seen = 1'b1;
            if (exp_q.size() == 0) chk("R10 unexpected delivery vec", int'(vec), 0);
            else chk("R1 delivered vector", int'(vec), exp_q.pop_front());
         end
         if (!int_w) int_seen = 1'b0;
      end
   end

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic pulse_req(input logic [7:0] m);
      req = m;
      cyc(1);
      req = '0;
   endtask

   task automatic wr_reg(input logic sel, input logic [7:0] d);
      reg_en = 1'b1; reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
      cyc(1);
      reg_en = 1'b0; reg_we = 1'b0;
   endtask

   task automatic rd_reg(input logic sel, input int exp, input string tag);
      reg_sel = sel; reg_en = 1'b1; reg_we = 1'b0;
      #1 chk(tag, int'(reg_rdata), exp);
      cyc(1);
      reg_en = 1'b0;
   endtask

   task automatic gie_toggle();
      gie = 1'b0;
      cyc(1);
      gie = 1'b1;
      cyc(1);
   endtask

   task automatic take_and_ack(input string tag);
      cyc(3);
      chk({tag, " int raised"}, int'(int_w), 1);
      chk({tag, " queue drained"}, exp_q.size(), 0);
      cyc(2);
      chk("R1 int held until ack", int'(int_w), 1);
      inta = 1'b1;
      cyc(1);
      inta = 1'b0;
      chk("R1 int cleared by ack", int'(int_w), 0);
   endtask

   task automatic no_int(input string tag);
      cyc(3);
      chk(tag, int'(int_w), 0);
   endtask

   initial begin
      cyc(3);
      rst_n = 1'b1;
      cyc(1);
      // R2 reset state
      chk("R2 int low", int'(int_w), 0);
      chk("R2 wait low", int'(wait_w), 0);
      rd_reg(1'b0, 8'h60, "R8 command read");
      rd_reg(1'b1, 8'h00, "R2 mask reset");

      // R3: idle level admits line 5 at once
      exp_q.push_back(13);
      pulse_req(8'h20);
      take_and_ack("R3 line5");
      gie_toggle();

      // R4: line 6 not below level 5 -> pended; line 2 admitted
      pulse_req(8'h40);
      no_int("R4 line6 held back");
      exp_q.push_back(10);
      pulse_req(8'h04);
      take_and_ack("R3 line2 preempts");
      gie_toggle();

      // R6: end of service walks 2 -> 5, line 6 still blocked
      wr_reg(1'b0, 8'h20);
      no_int("R6 walk stops at busy level 5");
      // R7: other command codes ignored
      wr_reg(1'b0, 8'h21);
      no_int("R7 code 0x21 ignored");
      wr_reg(1'b0, 8'h00);
      no_int("R7 code 0x00 ignored");
      exp_q.push_back(14);
      wr_reg(1'b0, 8'h20);
      take_and_ack("R6 walk to idle frees line6");
      gie_toggle();

      // R9 mask write/read; R11 wait status
      wr_reg(1'b1, 8'h01);
      rd_reg(1'b1, 8'h01, "R9 mask readback");
      gie = 1'b0;
      cyc(1);
      pulse_req(8'h03);
      cyc(2);
      chk("R11 wait high when disabled", int'(wait_w), 1);
      chk("R4 no delivery while disabled", int'(int_w), 0);
      exp_q.push_back(9);
      gie = 1'b1;
      #1 chk("R11 wait low when enabled", int'(wait_w), 0);
      take_and_ack("R10 line1 over masked line0");
      gie_toggle();
      exp_q.push_back(8);
      wr_reg(1'b1, 8'h00);
      take_and_ack("R9 unmask delivers line0");
      gie_toggle();

      // R6 walk through busy levels 0 -> 1 -> 6 -> 8
      wr_reg(1'b0, 8'h20);
      wr_reg(1'b0, 8'h20);
      wr_reg(1'b0, 8'h20);
      no_int("R6 walk with nothing pending");

      // R10: several pending, one per evaluation, lowest first
      gie = 1'b0;
      cyc(1);
      pulse_req(8'h98);
      cyc(2);
      chk("R11 wait with three pending", int'(wait_w), 1);
      exp_q.push_back(11);
      gie = 1'b1;
      take_and_ack("R10 line3 first");
      gie_toggle();
      no_int("R10 lines 4,7 wait behind level 3");
      exp_q.push_back(12);
      wr_reg(1'b0, 8'h20);
      take_and_ack("R10 line4 second");
      gie_toggle();
      exp_q.push_back(15);
      wr_reg(1'b0, 8'h20);
      take_and_ack("R10 line7 third");

      // R5: hold-off until the enable rises again
      pulse_req(8'h04);
      no_int("R5 held off after delivery");
      chk("R5 wait during hold-off", int'(wait_w), 1);
      exp_q.push_back(10);
      gie_toggle();
      take_and_ack("R5 re-enable releases line2");
      gie_toggle();

      // R6 back to idle, then end-of-service at idle
      wr_reg(1'b0, 8'h20);
      wr_reg(1'b0, 8'h20);
      wr_reg(1'b0, 8'h20);
      no_int("R6 idle end-of-service no effect");
      exp_q.push_back(15);
      pulse_req(8'h80);
      take_and_ack("R6 idle level admits line7");
      rd_reg(1'b0, 8'h60, "R8 command read later");

      cyc(2);
      chk("R1 no leftover expectations", exp_q.size(), 0);
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog act=1 exp=0");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

endmodule